// File: doc/BRIEF.md
# Power-Good Supervisor with Release Timer

This block watches a set of regulator channels and drives a single power-good level, where high means good. Each channel reports two synchronous comparator flags. One says its output has dropped under the low trip point, nominally 85 % of target. The other says its output has climbed over the high trip point, nominally 90 % of target. Because the two trip points differ, the output has hysteresis. A channel that sits between them neither pulls power-good down nor lets it come up.

Power-good falls on the first clock after any channel reports a low trip. A gating mask chooses which channels must report the high trip before release is allowed. Once that release condition holds, a delay counter advances on each switching-clock tick. Power-good rises one clock after the counter reaches `DELAY_TICKS`. The default is 10^6 ticks, which is one second at a 1 MHz switching rate, so the delay scales with the switching frequency. The pin is open-drain on silicon, but here it is a plain logic level.

Top module: `pg_supervisor`

## Requirements
- R1: During reset and on the first clock after reset is released, `pwr_good` is 0 and the delay count is zero.
- R2: If any bit of `ch_below_low` is 1 on a clock edge, `pwr_good` is 0 after that edge. This includes channels whose mask bit is 0.
- R3: `pwr_good` rises only after the release condition has held for `DELAY_TICKS` ticks. The release condition is: no `ch_below_low` bit is set, and every channel with `ch_gate_mask[i]=1` has `ch_above_high[i]=1`. With a tick on every clock, `pwr_good` rises on clock `DELAY_TICKS+1` after the condition first holds.
- R4: Once high, `pwr_good` stays high while no low-trip flag is set, even if high-trip flags drop (hysteresis).
- R5: If the release condition is lost before the count completes, the count returns to zero, and a full `DELAY_TICKS` ticks are needed afterwards.
- R6: Channels with `ch_gate_mask[i]=0` do not hold back release through their `ch_above_high` flag.
- R7: The counter advances only on clocks where `sw_tick` is 1. With ticks on alternate clocks, release takes twice as many clocks. With no ticks, `pwr_good` never rises.
- R8: The counter saturates at `DELAY_TICKS` and never wraps, so `pwr_good` remains high for as long as good conditions last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_tick | input | 1 | One-clock pulse per switching period |
| ch_below_low | input | NUM_CH | Per-channel low-trip flag (1 = under low threshold) |
| ch_above_high | input | NUM_CH | Per-channel high-trip flag (1 = over high threshold) |
| ch_gate_mask | input | NUM_CH | 1 = channel must be over high threshold before release |
| pwr_good | output | 1 | Registered power-good level, 1 = good |

## Verification
The hardest state to reach is a release condition that breaks partway through the delay and then recovers. Only that case shows whether the count truly restarts or just pauses. The stimulus counts five ticks, drops a single selected channel's high flag for one clock without raising any low flag, and then restores it. After that it expects `pwr_good` to stay low for a full delay. A second hard case is pacing the count with sparse ticks. A run with no ticks comes first, followed by alternate-clock ticks, and it shows that elapsed time is measured in switching periods rather than in clocks.

// File: rtl/pg_sup_pkg.sv
package pg_sup_pkg;

  typedef struct packed {
    logic any_low;     // some channel under its low trip
    logic release_ok;  // no low trip and every gated channel over high trip
  } chan_summary_t;

  typedef enum logic [1:0] {
    PG_HOLD = 2'd0,
    PG_WAIT = 2'd1,
    PG_GOOD = 2'd2
  } pg_state_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/pg_chan_eval.sv
module pg_chan_eval
  import pg_sup_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] below_low,
  input  logic [NUM_CH-1:0] above_high,
  input  logic [NUM_CH-1:0] gate_mask,
  output chan_summary_t     summary
);

  logic [NUM_CH-1:0] ready_vec;

  // A channel is ready when it is over its high trip or is not gating release.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ready_vec[i] = above_high[i] | ~gate_mask[i];
  end

  always_comb begin
    summary.any_low    = |below_low;
    summary.release_ok = (&ready_vec) & ~(|below_low);
  end

endmodule

// File: rtl/pg_release_timer.sv
module pg_release_timer #(
  parameter int unsigned DELAY_TICKS = 1000000,
  parameter int unsigned CNT_W       = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expired
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != TERM)) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count   = cnt_q;
  assign expired = (cnt_q == TERM);

endmodule

// File: rtl/pg_out_stage.sv
module pg_out_stage
  import pg_sup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic any_low,
  input  logic release_ok,
  input  logic expired,
  output logic good
);

  pg_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (any_low) begin
      st_d = PG_HOLD;
    end else begin
      unique case (st_q)
        PG_HOLD: if (release_ok) st_d = PG_WAIT;
        PG_WAIT: begin
          if (!release_ok)  st_d = PG_HOLD;
          else if (expired) st_d = PG_GOOD;
        end
        PG_GOOD: st_d = PG_GOOD;
        default: st_d = PG_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PG_HOLD;
    else     st_q <= st_d;
  end

  assign good = (st_q == PG_GOOD);

endmodule

// File: rtl/pg_supervisor.sv
module pg_supervisor
  import pg_sup_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DELAY_TICKS = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_tick,
  input  logic [NUM_CH-1:0] ch_below_low,
  input  logic [NUM_CH-1:0] ch_above_high,
  input  logic [NUM_CH-1:0] ch_gate_mask,
  output logic              pwr_good
);

  localparam int unsigned CNT_W = cnt_width(DELAY_TICKS);

  chan_summary_t    summ;
  logic [CNT_W-1:0] tmr_count;
  logic             tmr_expired;

  pg_chan_eval #(.NUM_CH(NUM_CH)) u_eval (
    .below_low  (ch_below_low),
    .above_high (ch_above_high),
    .gate_mask  (ch_gate_mask),
    .summary    (summ)
  );

  pg_release_timer #(.DELAY_TICKS(DELAY_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (summ.release_ok),
    .tick    (sw_tick),
    .count   (tmr_count),
    .expired (tmr_expired)
  );

  pg_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .any_low    (summ.any_low),
    .release_ok (summ.release_ok),
    .expired    (tmr_expired),
    .good       (pwr_good)
  );

endmodule

// File: rtl/pg_supervisor_chk.sv
module pg_supervisor_chk #(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned DELAY_TICKS = 1000000,
  parameter int unsigned CNT_W       = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_tick,
  input logic [NUM_CH-1:0] ch_below_low,
  input logic [NUM_CH-1:0] ch_above_high,
  input logic [NUM_CH-1:0] ch_gate_mask,
  input logic              pwr_good,
  input logic [CNT_W-1:0]  tmr_count
);

  localparam logic [CNT_W-1:0] TERM = CNT_W'(DELAY_TICKS);

  logic rel_cond;
  assign rel_cond = ~(|ch_below_low) & (&(ch_above_high | ~ch_gate_mask));

  // R1
  reset_low_chk: assert property (@(posedge clk) $past(rst) |-> (!pwr_good && tmr_count == '0));

  // R2
  low_trip_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (|ch_below_low) |=> !pwr_good);

  // R3
  rise_needs_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_good) |-> ($past(rel_cond) && $past(tmr_count) == TERM));

  // R4
  hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && !(|ch_below_low)) |=> pwr_good);

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    !rel_cond |=> (tmr_count == '0));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_cond && !sw_tick) |=> $stable(tmr_count));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_count <= TERM);

endmodule

bind pg_supervisor pg_supervisor_chk #(
  .NUM_CH(NUM_CH), .DELAY_TICKS(DELAY_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .sw_tick       (sw_tick),
  .ch_below_low  (ch_below_low),
  .ch_above_high (ch_above_high),
  .ch_gate_mask  (ch_gate_mask),
  .pwr_good      (pwr_good),
  .tmr_count     (tmr_count)
);

// File: tb/pg_supervisor_tb.sv
`timescale 1ns/1ps
module pg_supervisor_tb;

  localparam int unsigned N = 4;
  localparam int unsigned D = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sw_tick = 1'b0;
  logic [N-1:0] below = '0;
  logic [N-1:0] above = '0;
  logic [N-1:0] mask  = '1;
  logic         pwr_good;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  pg_supervisor #(.NUM_CH(N), .DELAY_TICKS(D)) u_dut (
    .clk           (clk),
    .rst           (rst),
    .sw_tick       (sw_tick),
    .ch_below_low  (below),
    .ch_above_high (above),
    .ch_gate_mask  (mask),
    .pwr_good      (pwr_good)
  );

  // Monitor: compares each registered result against the queued expectation.
  always @(posedge clk) begin
    #1;
    if (!rst && exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (pwr_good !== e) begin
        n_fail++;
        $display("FAIL %s: pwr_good=%0b expected=%0b at %0t", t, pwr_good, e, $time);
      end
    end
  end

  task automatic step(input logic [N-1:0] lo, input logic [N-1:0] hi,
                      input logic [N-1:0] sel, input logic tk,
                      input bit exp, input string tag);
    @(negedge clk);
    below = lo; above = hi; mask = sel; sw_tick = tk;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic clear_state();
    step(4'b0001, 4'b0000, 4'hF, 1'b1, 1'b0, "R2");
  endtask

  task automatic good_run(input logic [N-1:0] hi, input logic [N-1:0] sel, input string tag);
    for (int i = 1; i <= D; i++) step(4'b0000, hi, sel, 1'b1, 1'b0, tag);
    step(4'b0000, hi, sel, 1'b1, 1'b1, tag);
  endtask

  initial begin
    below = '0; above = '1; mask = '1; sw_tick = 1'b1;
    repeat (4) @(negedge clk);
    n_checks++;
    if (pwr_good !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pwr_good=%0b expected=0 during reset", pwr_good);
    end
    below = 4'b0001;
    @(negedge clk);
    rst = 1'b0;
    // R1: first clock after reset, still low
    step(4'b0000, 4'hF, 4'hF, 1'b1, 1'b0, "R1");
    clear_state();

    // R3: tick every clock, rise on clock D+1
    good_run(4'hF, 4'hF, "R3");
    // R8: stays high well beyond the terminal count
    for (int i = 0; i < 3*D; i++) step(4'b0000, 4'hF, 4'hF, 1'b1, 1'b1, "R8");
    // R4: high flags drop, no low trip, still good
    for (int i = 0; i < 5; i++) step(4'b0000, 4'b0101, 4'hF, 1'b1, 1'b1, "R4");
    // R2: one low trip drops output next clock
    step(4'b0100, 4'b0101, 4'hF, 1'b1, 1'b0, "R2");
    step(4'b0000, 4'b0101, 4'hF, 1'b1, 1'b0, "R4");

    // R5: interrupted count restarts from zero
    clear_state();
    for (int i = 0; i < 5; i++) step(4'b0000, 4'hF, 4'hF, 1'b1, 1'b0, "R5");
    step(4'b0000, 4'b1101, 4'hF, 1'b1, 1'b0, "R5");
    good_run(4'hF, 4'hF, "R5");

    // R6: unselected channel with no high flag does not block release
    clear_state();
    good_run(4'b0111, 4'b0111, "R6");

    // R2: unselected channel low trip still forces low
    step(4'b1000, 4'b0111, 4'b0111, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 2*D; i++) step(4'b1000, 4'b0111, 4'b0111, 1'b1, 1'b0, "R2");

    // R7: no ticks -> never rises; alternate ticks -> twice as long
    clear_state();
    for (int i = 0; i < 20; i++) step(4'b0000, 4'hF, 4'hF, 1'b0, 1'b0, "R7");
    for (int i = 1; i <= 2*D - 1; i++)
      step(4'b0000, 4'hF, 4'hF, logic'(i % 2), 1'b0, "R7");
    step(4'b0000, 4'hF, 4'hF, 1'b0, 1'b1, "R7");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule